// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block watches a two-wire serial bus for signs that a host processor is still running. The clock and data lines are resynchronised to the system clock. The block restarts its timeout counter each time it sees a complete, well-formed transaction: a START, at least one clock low/high cycle, then a STOP. The smallest such transaction carries no data bytes, so firmware can service the watchdog with only a few port toggles. If no transaction arrives within the selected interval, the block emits a one-cycle timeout request to the system reset generator.

A two-bit selection register chooses one of three interval lengths or turns the watchdog off. Each interval is a parameter counted in system clock cycles. Writes to the selection register are refused while the write-protect input is high. While the reset generator reports that its reset is active, the counter is held at zero. A timeout therefore cannot repeat until the reset has been released.

Top module: `bus_wdt`

## Requirements
- R1: While `rst_ni` is low, `timeout_o` is 0 and `cfg_sel_o` reads 2'b00.
- R2: With no bus activity and `rst_active_i` low, consecutive timeout pulses are exactly L cycles apart. L is `LONG_CYC` for selection 2'b00, `MID_CYC` for 2'b01 and `SHORT_CYC` for 2'b10.
- R3: `timeout_o` is high for exactly one cycle per timeout.
- R4: A START (SDA falls while SCL is high), then SCL low, then SCL high, then a STOP (SDA rises while SCL is high) restarts the counter. Counting the first rising clock edge after SDA rises at the pins as edge 1, the next timeout appears on edge L+3.
- R5: A START followed by a STOP with no SCL low phase between them does not restart the counter.
- R6: SDA transitions made while SCL is low are not START or STOP and do not restart the counter.
- R7: Selection 2'b11 disables the watchdog: `timeout_o` stays 0.
- R8: A write (`cfg_we_i` high) while `wp_i` is high leaves `cfg_sel_o` and the interval unchanged.
- R9: A write while `wp_i` is low loads `cfg_wdata_i` into `cfg_sel_o` at the next rising edge.
- R10: While `rst_active_i` is high the counter is held at zero and no timeout occurs. After release, counting the first rising edge with it low as edge 1, the timeout appears on edge L.
- R11: If a new selection makes the interval shorter than the count already reached, the timeout appears on the rising edge after the one that captured the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| wp_i | input | 1 | Write protect; high blocks selection writes |
| cfg_we_i | input | 1 | Selection register write strobe |
| cfg_wdata_i | input | 2 | Selection value to write |
| rst_active_i | input | 1 | Reset generator is asserting reset |
| cfg_sel_o | output | 2 | Current interval selection |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
Five properties are checked on every cycle by assertions:
- the single-cycle width of the timeout pulse;
- silence while the watchdog is disabled;
- silence while the reset generator holds reset;
- refusal of protected writes;
- loading of unprotected writes.

The exact interval lengths, the cycle at which a serviced counter next expires, and the rejection of malformed framing (a START straight into a STOP, or SDA toggling under a low SCL) are shown only by the bench's scenarios. The bench measures the cycle distance to each pulse and compares it against values derived from the parameters.

// File: rtl/bus_wdt_pkg.sv
package bus_wdt_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wdt_sel_e;
endpackage

// File: rtl/bus_wdt_sync.sv
module bus_wdt_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bus_wdt_frame.sv
module bus_wdt_frame (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic restart_o
);
  logic scl_q, sda_q, in_frame_q, seen_low_q;
  logic start, stop;

  assign start = scl_i & scl_q & sda_q & ~sda_i;
  assign stop  = scl_i & scl_q & ~sda_q & sda_i;
  // complete frame needs a low SCL phase between START and STOP
  assign restart_o = stop & in_frame_q & seen_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      in_frame_q <= 1'b0;
      seen_low_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start) begin
        in_frame_q <= 1'b1;
        seen_low_q <= 1'b0;
      end else if (stop) begin
        in_frame_q <= 1'b0;
        seen_low_q <= 1'b0;
      end else if (in_frame_q && !scl_i) begin
        seen_low_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_wdt_timer.sv
module bus_wdt_timer
  import bus_wdt_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 1400000,
  parameter int unsigned MID_CYC   = 600000,
  parameter int unsigned SHORT_CYC = 200000,
  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_sel_e sel_i,
  input  logic     restart_i,
  input  logic     hold_i,
  output logic     timeout_o
);
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic en, hit, timeout_q;

  always_comb begin
    unique case (sel_i)
      SEL_LONG:  lim_m1 = CNT_W'(LONG_CYC - 1);
      SEL_MID:   lim_m1 = CNT_W'(MID_CYC - 1);
      SEL_SHORT: lim_m1 = CNT_W'(SHORT_CYC - 1);
      default:   lim_m1 = '0;
    endcase
  end

  assign en  = (sel_i != SEL_OFF);
  // >= so a shortened interval expires at once
  assign hit = en & ~restart_i & ~hold_i & (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= hit;
      if (!en || restart_i || hold_i || hit) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = timeout_q;
endmodule

// File: rtl/bus_wdt.sv
module bus_wdt
  import bus_wdt_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 1400000,
  parameter int unsigned MID_CYC   = 600000,
  parameter int unsigned SHORT_CYC = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_wdata_i,
  input  logic       rst_active_i,
  output logic [1:0] cfg_sel_o,
  output logic       timeout_o
);
  wdt_sel_e   sel_q;
  logic [1:0] bus_s;
  logic       restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sel_q <= SEL_LONG;
    else if (cfg_we_i && !wp_i)     sel_q <= wdt_sel_e'(cfg_wdata_i);
  end

  assign cfg_sel_o = sel_q;

  bus_wdt_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  bus_wdt_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (bus_s[1]),
    .sda_i    (bus_s[0]),
    .restart_o(restart)
  );

  bus_wdt_timer #(
    .LONG_CYC (LONG_CYC),
    .MID_CYC  (MID_CYC),
    .SHORT_CYC(SHORT_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_q),
    .restart_i(restart),
    .hold_i   (rst_active_i),
    .timeout_o(timeout_o)
  );
endmodule

// File: rtl/bus_wdt_chk.sv
module bus_wdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       cfg_we_i,
  input logic [1:0] cfg_wdata_i,
  input logic       rst_active_i,
  input logic [1:0] cfg_sel_o,
  input logic       timeout_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!timeout_o && cfg_sel_o == 2'b00);
    end
  end

  assert_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_off_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_sel_o == 2'b11) |-> !timeout_o);

  assert_wp_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_i) |-> $stable(cfg_sel_o));

  assert_write_loads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i && !wp_i) |-> cfg_sel_o == $past(cfg_wdata_i));

  assert_hold_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_active_i) |-> !timeout_o);
endmodule

bind bus_wdt bus_wdt_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wp_i        (wp_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .rst_active_i(rst_active_i),
  .cfg_sel_o   (cfg_sel_o),
  .timeout_o   (timeout_o)
);

// File: tb/bus_wdt_tb.sv
module bus_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LONG  = 44;
  localparam int MID   = 28;
  localparam int SHORT = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, wp_i = 1'b0, cfg_we_i = 1'b0, rst_active_i = 1'b0;
  logic [1:0] cfg_wdata_i = 2'b00;
  logic [1:0] cfg_sel_o;
  logic timeout_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_wdt #(.LONG_CYC(LONG), .MID_CYC(MID), .SHORT_CYC(SHORT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .rst_active_i(rst_active_i),
    .cfg_sel_o(cfg_sel_o), .timeout_o(timeout_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int lim(input int s);
    return (s == 0) ? LONG : (s == 1) ? MID : SHORT;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // rising edges until a timeout is seen; -1 if none within maxn
  task automatic meas(input int maxn, output int n);
    int k = 0;
    bit hit = 0;
    while (!hit && k < maxn) begin
      @(posedge clk_i);
      k++;
      @(negedge clk_i);
      hit = timeout_o;
    end
    n = hit ? k : -1;
  endtask

  task automatic wr(input logic [1:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    int n;
    step(3);
    check("R1 timeout", int'(timeout_o), 0);
    check("R1 sel", int'(cfg_sel_o), 0);
    rst_ni = 1'b1;
    step(1);

    for (int s = 0; s < 3; s++) begin
      wr(2'(s));
      check("R9 sel loaded", int'(cfg_sel_o), s);
      meas(3 * LONG, n);
      check("R2 first timeout seen", int'(n > 0), 1);
      meas(3 * LONG, n);
      check("R2 period", n, lim(s));
      step(1);
      check("R3 pulse width", int'(timeout_o), 0);
      // minimal frame: START, SCL low, SCL high, STOP
      sda_i = 1'b0; step(2);
      scl_i = 1'b0; step(2);
      scl_i = 1'b1; step(2);
      sda_i = 1'b1;
      meas(3 * LONG, n);
      check("R4 restart", n, lim(s) + 3);
      // START then STOP, no SCL low phase
      sda_i = 1'b0; step(2);
      sda_i = 1'b1;
      meas(3 * LONG, n);
      check("R5 bare start/stop ignored", n, lim(s) - 2);
      // SDA toggles under low SCL
      scl_i = 1'b0; step(2);
      sda_i = 1'b0; step(2);
      sda_i = 1'b1; step(2);
      scl_i = 1'b1; step(2);
      meas(3 * LONG, n);
      check("R6 data toggles ignored", n, lim(s) - 8);
    end

    // R7 disabled
    wr(2'b11);
    meas(3 * LONG, n);
    check("R7 disabled", n, -1);

    // R8 write protect, interval stays long
    wr(2'b00);
    meas(3 * LONG, n);
    wp_i = 1'b1;
    wr(2'b10);
    check("R8 sel kept", int'(cfg_sel_o), 0);
    meas(3 * LONG, n);
    check("R8 period kept", n, LONG - 1);
    wp_i = 1'b0;

    // R10 hold while reset active
    rst_active_i = 1'b1;
    meas(2 * LONG, n);
    check("R10 held silent", n, -1);
    rst_active_i = 1'b0;
    meas(3 * LONG, n);
    check("R10 after release", n, LONG);

    // R11 shorten interval below current count
    step(30);
    wr(2'b10);
    meas(3 * LONG, n);
    check("R11 early timeout", n, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule